// File: doc/BRIEF.md
# Multi-Lane Byte Merger

This block sits behind the byte aligners of a serial display link receiver. One to four data lanes each hand it one byte per clock, with a valid flag and markers for the start and the end of a high-speed burst. The block rebuilds the byte stream the transmitter sent. Bytes are dealt to the lanes in rotation starting at lane 0, so each output beat carries one byte per enabled lane, packed with the lowest lane first. A flag marks the first beat of a burst and another marks the beat that holds its final byte.

The number of enabled lanes comes from two strap inputs. They are captured while the synchronous reset is held and are frozen once it is released. Lane 0 is always in use. After reset the block spends a fixed start-up window with `init_busy` high. During that window it ignores the lanes and watches that the clock lane stays idle. It also checks that enabled lanes start bursts together, run in lockstep and finish at most one byte apart. Faults are reported on two sticky error flags that only reset clears.

A four-state controller sequences the work:
- **INIT**: the start-up window. It moves to IDLE when the window count expires.
- **IDLE**: waits for a start marker. An aligned start moves to BURST, to TAIL if some lanes end on the first beat, or stays in IDLE if every lane ends on the first beat. A misaligned start stays in IDLE and raises the alignment error.
- **BURST**: merges full beats. It moves to IDLE when all lanes end together, or to TAIL when only the upper lanes end.
- **TAIL**: waits for the final byte of the lower lanes and then returns to IDLE.

Top module: `lane_byte_merger`

## Requirements
- R1: The lane count is the strap value plus one (00 = 1 lane, 01 = 2, 10 = 3, 11 = 4), taken from the level on `lane_strap` while `rst_n` is low, and reported on `active_lanes`.
- R2: Changes on `lane_strap` after reset release do not change `active_lanes` or lane usage until the next reset.
- R3: Lane 0 is always enabled. Valid, start, end and data on lanes at or above the lane count have no effect on the output or on the error flags.
- R4: Each output beat carries one byte per valid enabled lane, with lane k's byte at `out_data[8k+7:8k]` and `out_nbytes` giving the count. Read beat after beat, the bytes form the original stream in order, which the transmitter dealt out in rotation from lane 0.
- R5: A burst starts when every enabled lane shows valid and start in the same cycle. The matching output beat appears one clock later with `out_first` high.
- R6: A start marker that is not on every enabled lane sets `align_err`. That cycle produces no output. `align_err` stays set until reset.
- R7: Inside a burst, a cycle in which some but not all enabled lanes are valid sets `align_err`, and that cycle's bytes are not output.
- R8: Upper lanes may send their end marker one beat before the lower lanes. The lower lanes' final bytes then come out in a following beat, and that beat carries `out_last`.
- R9: A burst in which every enabled lane shows start and end on the same beat produces one beat with both `out_first` and `out_last`.
- R10: `init_busy` is high for INIT_CYCLES clock cycles from reset release and never rises again. Lane inputs during that window produce no output.
- R11: If `clk_lane_idle` is low in any cycle while `init_busy` is high, `init_err` is set and stays set until reset. It stays clear otherwise.
- R12: `out_last` is high exactly on the beat that carries the final byte of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset; strap captured while low |
| lane_strap | input | 2 | Lane count strap, value plus one lanes |
| clk_lane_idle | input | 1 | High while the clock lane is in its idle line state |
| lane_valid | input | 4 | Per-lane byte valid |
| lane_sot | input | 4 | Per-lane start of burst marker |
| lane_eot | input | 4 | Per-lane end of burst marker, with the lane's last byte |
| lane_data | input | 32 | Per-lane byte, lane k in bits 8k+7:8k |
| init_busy | output | 1 | High during the start-up window |
| active_lanes | output | 3 | Latched number of enabled lanes |
| out_valid | output | 1 | Output beat present |
| out_data | output | 32 | Packed output bytes, first byte in bits 7:0 |
| out_nbytes | output | 3 | Number of bytes in the beat |
| out_first | output | 1 | Beat opens a burst |
| out_last | output | 1 | Beat holds the final byte of a burst |
| align_err | output | 1 | Sticky lane alignment error |
| init_err | output | 1 | Sticky start-up clock lane error |

## Verification
The bench replays bursts whose byte counts are not multiples of the lane count, so the upper lanes end one beat early. A merger that closed the burst on the first end marker would drop the lower lanes' last bytes or raise `out_last` one beat early. Single-beat bursts, pauses in the middle of a burst and garbage on disabled lanes cover three more faults: a missing first/last pair, a stall mistaken for a fault, and a disabled lane leaking bytes or false errors. Misaligned starts, a lane dropping out mid-burst, strap changes after reset and a clock lane that is not idle during start-up check that each fault raises its flag, that no bytes leak and that the lane count stays latched.

// File: rtl/merger_pkg.sv
package merger_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_BURST = 2'd2,
        ST_TAIL  = 2'd3
    } merge_state_t;
endpackage

// File: rtl/merger_strap_latch.sv
module merger_strap_latch #(
    parameter int LANES = 4,
    localparam int SW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    strap,
    output logic [LANES-1:0] en_mask,
    output logic [SW:0]      active_cnt
);
    logic [SW-1:0] sel_q;

    // Tracks the strap while reset is held, so the value at release is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= strap;
    end

    assign active_cnt = (SW+1)'(sel_q) + (SW+1)'(1);

    for (genvar i = 0; i < LANES; i++) begin : g_en
        assign en_mask[i] = (int'(sel_q) >= i);
    end

    assert_count_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(sel_q));
endmodule

// File: rtl/merger_init_mon.sv
module merger_init_mon #(
    parameter int INIT_CYCLES = 16,
    localparam int CW = $clog2(INIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_init,
    input  logic clk_idle,
    output logic done,
    output logic err
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err   <= 1'b0;
        end else begin
            if (in_init) cnt_q <= cnt_q + CW'(1);
            if (in_init && !clk_idle) err <= 1'b1;
        end
    end

    assign done = in_init && (cnt_q == CW'(INIT_CYCLES - 1));

    assert_init_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/merger_lane_mask.sv
module merger_lane_mask #(
    parameter int LANES = 4,
    parameter int BW = 8,
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]    en,
    input  logic [LANES-1:0]    valid,
    input  logic [LANES-1:0]    sot,
    input  logic [LANES-1:0]    eot,
    input  logic [LANES*BW-1:0] data,
    output logic [LANES-1:0]    vm,
    output logic [LANES-1:0]    sm,
    output logic [LANES-1:0]    em,
    output logic [LANES*BW-1:0] dm,
    output logic [NW-1:0]       nbytes
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign vm[i] = valid[i] & en[i];
        assign sm[i] = sot[i] & vm[i];
        assign em[i] = eot[i] & vm[i];
        assign dm[i*BW +: BW] = vm[i] ? data[i*BW +: BW] : '0;
    end

    always_comb nbytes = NW'($countones(vm));
endmodule

// File: rtl/lane_byte_merger.sv
module lane_byte_merger
    import merger_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BW = 8,
    parameter int INIT_CYCLES = 16,
    localparam int SW = $clog2(LANES),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SW-1:0]       lane_strap,
    input  logic                clk_lane_idle,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES-1:0]    lane_sot,
    input  logic [LANES-1:0]    lane_eot,
    input  logic [LANES*BW-1:0] lane_data,
    output logic                init_busy,
    output logic [SW:0]         active_lanes,
    output logic                out_valid,
    output logic [LANES*BW-1:0] out_data,
    output logic [NW-1:0]       out_nbytes,
    output logic                out_first,
    output logic                out_last,
    output logic                align_err,
    output logic                init_err
);
    merge_state_t st_q, st_d;
    logic [LANES-1:0]    en, vm, sm, em, pend_q, pend_d, pend_new;
    logic [LANES*BW-1:0] dm;
    logic [NW-1:0]       nb;
    logic                init_done, emit, first, last, bad;

    function automatic logic low_run(input logic [LANES-1:0] m);
        return ((m & (m + LANES'(1))) == '0);
    endfunction

    merger_strap_latch #(.LANES(LANES)) u_strap (
        .clk(clk), .rst_n(rst_n), .strap(lane_strap),
        .en_mask(en), .active_cnt(active_lanes)
    );

    merger_init_mon #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk(clk), .rst_n(rst_n), .in_init(st_q == ST_INIT),
        .clk_idle(clk_lane_idle), .done(init_done), .err(init_err)
    );

    merger_lane_mask #(.LANES(LANES), .BW(BW)) u_mask (
        .en(en), .valid(lane_valid), .sot(lane_sot), .eot(lane_eot),
        .data(lane_data), .vm(vm), .sm(sm), .em(em), .dm(dm), .nbytes(nb)
    );

    assign pend_new  = en & ~em;
    assign init_busy = (st_q == ST_INIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_INIT;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    // Next state and beat decisions
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        emit   = 1'b0;
        first  = 1'b0;
        last   = 1'b0;
        bad    = 1'b0;
        unique case (st_q)
            ST_INIT: begin
                if (init_done) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (sm != '0) begin
                    if (sm == en && vm == en) begin
                        emit  = 1'b1;
                        first = 1'b1;
                        if (em == en) begin
                            last = 1'b1;
                        end else if (em != '0) begin
                            st_d   = ST_TAIL;
                            pend_d = pend_new;
                            bad    = !low_run(pend_new);
                        end else begin
                            st_d = ST_BURST;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
            end
            ST_BURST: begin
                if (vm != '0) begin
                    if (vm != en) begin
                        bad = 1'b1;
                    end else begin
                        emit = 1'b1;
                        if (em == en) begin
                            last = 1'b1;
                            st_d = ST_IDLE;
                        end else if (em != '0) begin
                            st_d   = ST_TAIL;
                            pend_d = pend_new;
                            bad    = !low_run(pend_new);
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (vm != '0) begin
                    st_d = ST_IDLE;
                    if (vm == pend_q && em == pend_q) begin
                        emit = 1'b1;
                        last = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
            end
            default: st_d = ST_INIT;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_nbytes <= '0;
            out_first  <= 1'b0;
            out_last   <= 1'b0;
            align_err  <= 1'b0;
        end else begin
            out_valid  <= emit;
            out_data   <= emit ? dm : '0;
            out_nbytes <= emit ? nb : '0;
            out_first  <= first;
            out_last   <= last;
            align_err  <= align_err | bad;
        end
    end

    assert_nbytes_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nbytes != '0) && (int'(out_nbytes) <= int'(active_lanes)));

    assert_first_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid && (int'(out_nbytes) == int'(active_lanes)));

    assert_align_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

    assert_quiet_in_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> !out_valid);

    assert_busy_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |=> !init_busy);

    assert_last_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: tb/test_lane_byte_merger.sv
`timescale 1ns/1ps
module test_lane_byte_merger;
    localparam int LANES = 4;
    localparam int BW = 8;
    localparam int INIT_CYCLES = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic [1:0]         lane_strap = 2'b11;
    logic               clk_lane_idle = 1'b1;
    logic [LANES-1:0]   lane_valid = '0, lane_sot = '0, lane_eot = '0;
    logic [LANES*BW-1:0] lane_data = '0;
    logic               init_busy, out_valid, out_first, out_last, align_err, init_err;
    logic [2:0]         active_lanes, out_nbytes;
    logic [LANES*BW-1:0] out_data;

    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    int size_q[$];
    int remain = 0;
    int n_act = 4;

    lane_byte_merger #(.LANES(LANES), .BW(BW), .INIT_CYCLES(INIT_CYCLES)) i_lane_byte_merger (
        .clk(clk), .rst_n(rst_n), .lane_strap(lane_strap), .clk_lane_idle(clk_lane_idle),
        .lane_valid(lane_valid), .lane_sot(lane_sot), .lane_eot(lane_eot), .lane_data(lane_data),
        .init_busy(init_busy), .active_lanes(active_lanes), .out_valid(out_valid),
        .out_data(out_data), .out_nbytes(out_nbytes), .out_first(out_first),
        .out_last(out_last), .align_err(align_err), .init_err(init_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference: stream of expected bytes and burst sizes, compared on every clock
    always @(negedge clk) begin
        int take;
        bit newp;
        logic [7:0] got, e;
        if (rst_n && out_valid) begin
            take = int'(out_nbytes);
            newp = (remain == 0);
            if (newp) begin
                if (size_q.size() == 0) chk(0, "R4", "beat with no burst pending", take, 0);
                else remain = size_q.pop_front();
            end
            chk(out_first == newp, "R5", "out_first", out_first, newp);
            for (int k = 0; k < take; k++) begin
                got = out_data[k*BW +: BW];
                if (exp_q.size() == 0) chk(0, "R4", "extra byte", got, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(got == e, "R4", "byte order", got, e);
                end
            end
            remain = remain - take;
            if (remain < 0) remain = 0;
            chk(out_last == (remain == 0), "R12", "out_last", out_last, remain == 0);
        end
    end

    // Quiet cycle: enabled lanes idle, disabled lanes carry garbage (R3)
    task automatic drive_quiet();
        logic [LANES-1:0] v = '0, s = '0, e = '0;
        logic [LANES*BW-1:0] d = '0;
        for (int j = n_act; j < LANES; j++) begin
            v[j] = 1'($urandom); s[j] = 1'($urandom); e[j] = 1'($urandom);
            d[j*BW +: BW] = 8'($urandom);
        end
        lane_valid = v; lane_sot = s; lane_eot = e; lane_data = d;
    endtask

    task automatic send_pkt(input int nb, input bit pause);
        int n = n_act;
        int beats = (nb + n - 1) / n;
        size_q.push_back(nb);
        for (int c = 0; c < beats; c++) begin
            logic [LANES-1:0] v = '0, s = '0, e = '0;
            logic [LANES*BW-1:0] d = '0;
            for (int j = 0; j < LANES; j++) begin
                int idx = c * n + j;
                if (j < n) begin
                    if (idx < nb) begin
                        v[j] = 1'b1;
                        s[j] = (c == 0);
                        e[j] = (idx + n >= nb);
                        d[j*BW +: BW] = 8'($urandom);
                        exp_q.push_back(d[j*BW +: BW]);
                    end
                end else begin
                    v[j] = 1'($urandom); s[j] = 1'($urandom); e[j] = 1'($urandom);
                    d[j*BW +: BW] = 8'($urandom);
                end
            end
            @(negedge clk);
            lane_valid = v; lane_sot = s; lane_eot = e; lane_data = d;
            if (pause && c == 0) begin
                @(negedge clk);
                drive_quiet();
            end
        end
        @(negedge clk);
        drive_quiet();
    endtask

    task automatic do_reset(input logic [1:0] st, input bit idle_ok);
        int busy;
        @(negedge clk);
        rst_n = 1'b0;
        lane_strap = st;
        clk_lane_idle = idle_ok;
        lane_valid = '0; lane_sot = '0; lane_eot = '0; lane_data = '0;
        remain = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && align_err == 0 && init_err == 0, "R1", "reset state",
            {out_valid, align_err, init_err}, 0);
        rst_n = 1'b1;
        n_act = int'(st) + 1;
        busy = 0;
        #1;
        while (init_busy && busy < 100) begin
            busy++;
            lane_valid = '1; lane_sot = '1; lane_eot = '0; lane_data = 32'($urandom);
            @(negedge clk);
        end
        drive_quiet();
        chk(busy == INIT_CYCLES, "R10", "init_busy cycles", busy, INIT_CYCLES);
        chk(active_lanes == 3'(n_act), "R1", "active_lanes", active_lanes, n_act);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Four lanes
        do_reset(2'b11, 1'b1);
        lane_strap = 2'b00;
        repeat (4) @(negedge clk);
        chk(active_lanes == 3'd4, "R2", "strap change after release", active_lanes, 4);
        chk(init_err == 0, "R11", "init_err with idle clock lane", init_err, 0);
        send_pkt(16, 1'b0);
        send_pkt(13, 1'b0);   // R8 lane 0 one byte later
        send_pkt(4, 1'b0);    // R9 single beat
        send_pkt(7, 1'b1);    // R8 with a pause
        repeat (3) @(negedge clk);
        chk(align_err == 0, "R5", "clean bursts keep align_err low", align_err, 0);

        // One lane, garbage on the others
        do_reset(2'b00, 1'b1);
        send_pkt(5, 1'b0);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            lane_valid = 4'b1110; lane_sot = 4'b1110; lane_eot = 4'b0110;
            lane_data = 32'($urandom);
        end
        @(negedge clk);
        drive_quiet();
        repeat (3) @(negedge clk);
        chk(align_err == 0, "R3", "disabled lanes raise no error", align_err, 0);

        // Two lanes: tail, then a misaligned start
        do_reset(2'b01, 1'b1);
        send_pkt(9, 1'b0);
        repeat (2) @(negedge clk);
        chk(align_err == 0, "R8", "tail is not an error", align_err, 0);
        lane_valid = 4'b0011; lane_sot = 4'b0001; lane_eot = '0; lane_data = 32'($urandom);
        @(negedge clk);
        drive_quiet();
        repeat (2) @(negedge clk);
        chk(align_err == 1, "R6", "misaligned start", align_err, 1);
        send_pkt(4, 1'b0);
        repeat (3) @(negedge clk);
        chk(align_err == 1, "R6", "align_err sticky", align_err, 1);

        // Three lanes: clean tail, then a lane drops mid-burst
        do_reset(2'b10, 1'b1);
        send_pkt(10, 1'b0);
        repeat (2) @(negedge clk);
        chk(align_err == 0, "R7", "align_err before fault", align_err, 0);
        size_q.push_back(6);
        lane_valid = 4'b0111; lane_sot = 4'b0111; lane_eot = '0; lane_data = 32'($urandom);
        for (int j = 0; j < 3; j++) exp_q.push_back(lane_data[j*8 +: 8]);
        @(negedge clk);
        lane_valid = 4'b0101; lane_sot = '0; lane_data = 32'($urandom);
        @(negedge clk);
        lane_valid = 4'b0111; lane_eot = 4'b0111; lane_data = 32'($urandom);
        for (int j = 0; j < 3; j++) exp_q.push_back(lane_data[j*8 +: 8]);
        @(negedge clk);
        drive_quiet();
        repeat (3) @(negedge clk);
        chk(align_err == 1, "R7", "partial beat in burst", align_err, 1);

        // Clock lane not idle during start-up
        do_reset(2'b11, 1'b0);
        clk_lane_idle = 1'b1;
        repeat (3) @(negedge clk);
        chk(init_err == 1, "R11", "init_err set", init_err, 1);
        chk(align_err == 0, "R6", "align_err cleared by reset", align_err, 0);
        send_pkt(8, 1'b0);
        repeat (4) @(negedge clk);
        chk(init_err == 1, "R11", "init_err sticky", init_err, 1);

        chk(exp_q.size() == 0, "R4", "bytes left unsent", exp_q.size(), 0);
        chk(size_q.size() == 0 && remain == 0, "R12", "bursts left open", size_q.size() + remain, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule